// File: doc/BRIEF.md
# Keyboard Receiver Register Pair

This peripheral sits on a 32-bit word-addressed read bus and captures characters delivered by a keyboard source as a byte with a one-cycle valid strobe. It exposes two registers in the I/O region of the address map. A status word carries a character-waiting flag and a sticky lost-character flag. A data word carries the most recent character.

Software polls the status word until the waiting flag is set, then reads the data word. That read returns the character and drops the waiting flag on the same clock edge. The block also tells the rest of the system which addresses belong to I/O rather than memory, through a select output.

Read data is combinational from the address and read strobe. Side effects of a read take place on the clock edge that ends the read cycle.

Top module: `kbd_rx_regs`

## Requirements
- R1: `io_sel` is 1 exactly when `bus_addr` is at or above 0xFFFF0000, independent of `bus_rd`.
- R2: A read (`bus_rd`=1) at 0xFFFF0000 returns the status word. Bit 0 is the waiting flag, bit 1 is the lost-character flag, and bits 31:2 are 0.
- R3: A read at 0xFFFF0004 returns the stored character in bits 7:0, with bits 31:8 at 0.
- R4: A cycle with `key_valid`=1 stores `key_byte` and sets the waiting flag from the next cycle.
- R5: A data read with no key in the same cycle clears the waiting flag from the next cycle. The read itself still returns the stored character.
- R6: A key that arrives while the waiting flag is 1, with no data read in that cycle, overwrites the character, keeps the waiting flag at 1 and sets the lost-character flag.
- R7: A status read clears the lost-character flag from the next cycle. If a new lost-character event occurs in the same cycle, the flag stays 1.
- R8: A key that arrives in the same cycle as a data read takes priority. The new byte is stored, the waiting flag stays 1, and the lost-character flag does not change.
- R9: After reset both flags are 0 and the stored character is 0.
- R10: Any read at another address, or any cycle with `bus_rd`=0, returns 0 and changes no state. This includes unaligned addresses inside the register pair.
- R11: A status read leaves the waiting flag unchanged, and a data read leaves the lost-character flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_byte | input | 8 | Character from the keyboard source |
| key_valid | input | 1 | One-cycle strobe qualifying `key_byte` |
| bus_addr | input | 32 | Byte address of the bus read |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| io_sel | output | 1 | Address lies in the I/O region |

## Verification
The bench targets the collisions between a key arriving and either kind of read:
- A design that lets the read win a key/data-read collision loses the new character and reports nothing waiting.
- A design that clears the lost-character flag despite a same-cycle overrun hides a dropped key.

It also probes the exact boundary of the I/O region and unaligned addresses next to the registers. An off-by-one decoder would either misroute memory traffic or attach side effects to the wrong address. A long pseudo-random sweep mixes all three actions against an arithmetic model, which exposes any read that clears the wrong flag.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef struct packed {
        logic              ready;
        logic              overrun;
        logic [CHAR_W-1:0] char_val;
    } rx_state_t;

    typedef struct packed {
        logic io_sel;
        logic ctrl_rd;
        logic data_rd;
    } bus_dec_t;

endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode #(
    parameter int unsigned        ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  IO_BASE   = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0]  DATA_ADDR = 32'hFFFF_0004
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_rd,
    output kbd_rx_pkg::bus_dec_t      dec
);
    import kbd_rx_pkg::*;

    always_comb begin
        dec         = '0;
        dec.io_sel  = (bus_addr >= IO_BASE);
        dec.ctrl_rd = bus_rd && (bus_addr == CTRL_ADDR);
        dec.data_rd = bus_rd && (bus_addr == DATA_ADDR);
    end

    // R1: a register hit always lies inside the I/O region under a read strobe
    p_hit_in_io_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ctrl_rd || dec.data_rd) |-> (dec.io_sel && bus_rd));

    // R10: at most one register is addressed per cycle
    p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec.ctrl_rd, dec.data_rd}));

endmodule

// File: rtl/kbd_rx_state.sv
module kbd_rx_state
    import kbd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    input  logic              ctrl_rd,
    input  logic              data_rd,
    output rx_state_t         st
);
    rx_state_t st_d, st_q;
    logic      lost_evt;

    always_comb begin
        st_d     = st_q;
        lost_evt = key_valid && st_q.ready && !data_rd;

        if (key_valid) begin
            st_d.char_val = key_byte;
            st_d.ready    = 1'b1;
        end else if (data_rd) begin
            st_d.ready    = 1'b0;
        end

        if (lost_evt) begin
            st_d.overrun = 1'b1;
        end else if (ctrl_rd) begin
            st_d.overrun = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    p_key_sets_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (st_q.ready && st_q.char_val == $past(key_byte)));

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !key_valid) |=> !st_q.ready);

    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && st_q.ready && !data_rd) |=> st_q.overrun);

    p_ctrl_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !(key_valid && st_q.ready && !data_rd)) |=> !st_q.overrun);

    p_collide_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && data_rd) |=> (st_q.ready && $stable(st_q.overrun)));

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && !ctrl_rd && !data_rd) |=> $stable(st_q));

endmodule

// File: rtl/kbd_rd_mux.sv
module kbd_rd_mux
    import kbd_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  bus_dec_t           dec,
    input  rx_state_t          st,
    output logic [DATA_W-1:0]  rdata
);
    localparam int unsigned FLAG_W = 2;

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] data_word;

    generate
        if (DATA_W > FLAG_W) begin : g_ctrl_pad
            assign ctrl_word = {{(DATA_W-FLAG_W){1'b0}}, st.overrun, st.ready};
        end else begin : g_ctrl_bare
            assign ctrl_word = {st.overrun, st.ready};
        end
        if (DATA_W > CHAR_W) begin : g_data_pad
            assign data_word = {{(DATA_W-CHAR_W){1'b0}}, st.char_val};
        end else begin : g_data_bare
            assign data_word = st.char_val[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (dec.ctrl_rd) begin
            rdata = ctrl_word;
        end else if (dec.data_rd) begin
            rdata = data_word;
        end
    end

endmodule

// File: rtl/kbd_rx_regs.sv
module kbd_rx_regs #(
    parameter int unsigned        ADDR_W    = 32,
    parameter int unsigned        DATA_W    = 32,
    parameter logic [ADDR_W-1:0]  IO_BASE   = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0]  DATA_ADDR = 32'hFFFF_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        key_byte,
    input  logic              key_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              io_sel
);
    import kbd_rx_pkg::*;

    bus_dec_t  dec;
    rx_state_t st;

    kbd_addr_decode #(
        .ADDR_W    (ADDR_W),
        .IO_BASE   (IO_BASE),
        .CTRL_ADDR (CTRL_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .dec      (dec)
    );

    kbd_rx_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_byte  (key_byte),
        .ctrl_rd   (dec.ctrl_rd),
        .data_rd   (dec.data_rd),
        .st        (st)
    );

    kbd_rd_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .dec   (dec),
        .st    (st),
        .rdata (bus_rdata)
    );

    assign io_sel = dec.io_sel;

    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CTRL_ADDR) |-> (bus_rdata[DATA_W-1:2] == '0));

    p_data_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_ADDR) |-> (bus_rdata[DATA_W-1:8] == '0));

    p_no_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (st == '0));

endmodule

// File: tb/kbd_rx_regs_tb.sv
module kbd_rx_regs_tb;
    localparam logic [31:0] CTRL = 32'hFFFF_0000;
    localparam logic [31:0] DATA = 32'hFFFF_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  key_byte = '0;
    logic        key_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        io_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       m_ready = 1'b0;
    logic       m_ovr   = 1'b0;
    logic [7:0] m_char  = '0;

    always #10 clk = ~clk;

    kbd_rx_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_byte  (key_byte),
        .key_valid (key_valid),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .io_sel    (io_sel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic kv, input logic [7:0] kb, input logic rd,
                      input logic [31:0] addr, input string tag);
        logic [31:0] exp_rd;
        logic        d_rd, c_rd;
        @(negedge clk);
        key_valid = kv; key_byte = kb; bus_rd = rd; bus_addr = addr;
        d_rd = rd && (addr == DATA);
        c_rd = rd && (addr == CTRL);
        exp_rd = c_rd ? {30'd0, m_ovr, m_ready} : (d_rd ? {24'd0, m_char} : 32'd0);
        #5;
        check({tag, " rdata"}, bus_rdata, exp_rd);
        check("R1 io_sel", {31'd0, io_sel}, {31'd0, addr >= 32'hFFFF_0000});
        @(posedge clk);
        if (kv && m_ready && !d_rd) m_ovr = 1'b1;
        else if (c_rd)              m_ovr = 1'b0;
        if (kv) begin m_ready = 1'b1; m_char = kb; end
        else if (d_rd) m_ready = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] addrs [8];
        addrs[0] = CTRL; addrs[1] = DATA; addrs[2] = CTRL; addrs[3] = DATA;
        addrs[4] = 32'hFFFF_0008; addrs[5] = 32'hFFFE_FFFC;
        addrs[6] = 32'hFFFF_0001; addrs[7] = 32'h0000_0004;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        op(0, 8'h00, 1, CTRL, "R9 reset status");
        op(0, 8'h00, 1, DATA, "R9 reset char");
        op(1, 8'h41, 0, 32'h0, "R4 key load");
        op(0, 8'h00, 1, CTRL, "R4 ready set");
        op(0, 8'h00, 1, CTRL, "R11 status read keeps ready");
        op(0, 8'h00, 1, DATA, "R3 char read");
        op(0, 8'h00, 1, CTRL, "R5 ready cleared");
        op(1, 8'h42, 0, 32'h0, "R4 key");
        op(1, 8'h43, 0, 32'h0, "R6 overrun key");
        op(0, 8'h00, 1, DATA, "R6 overwrite char");
        op(0, 8'h00, 1, CTRL, "R11 overrun survives data read");
        op(0, 8'h00, 1, CTRL, "R7 overrun cleared");
        op(1, 8'h50, 0, 32'h0, "R4 key");
        op(1, 8'h51, 1, CTRL, "R7 clear vs event");
        op(0, 8'h00, 1, CTRL, "R7 overrun retained");
        op(1, 8'h52, 1, DATA, "R8 collision");
        op(0, 8'h00, 1, CTRL, "R8 ready kept");
        op(0, 8'h00, 1, 32'hFFFF_0008, "R10 other io addr");
        op(0, 8'h00, 1, 32'hFFFF_0005, "R10 unaligned");
        op(0, 8'h00, 0, DATA, "R10 no strobe");
        op(0, 8'h00, 1, DATA, "R8 new char");
        op(0, 8'h00, 0, 32'hFFFE_FFFF, "R1 below base");
        op(0, 8'h00, 0, 32'hFFFF_FFFF, "R1 top");

        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            string tg;
            logic [31:0] a;
            a = addrs[lfsr[4:2]];
            tg = (a == CTRL) ? "R2 sweep" : ((a == DATA) ? "R3 sweep" : "R10 sweep");
            op(lfsr[0], lfsr[15:8], lfsr[1] | lfsr[5], a, tg);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule